// File: doc/BRIEF.md
# Dual-Rail Interleaved Substitution Table

This block is an 8-bit-in, 32-bit-out substitution table whose answers leave it in a dual-rail interleaved form. In that form every data bit sits next to its complement. It is meant to sit behind a processor's custom-operation slot. The block holds several independent tables. Each table is split across two 256-word on-chip memories. One memory serves the low half-word of every entry and the other serves the high half-word. Each memory word is already balanced: bit i of the half-word is stored at position 2i and its inverse at position 2i+1. The two memories therefore never hold inverses of each other.

The index also arrives in dual-rail form, as a 16-bit word. Index bit i is on bit 2i and its inverse is on bit 2i+1. The low-half memory is addressed from the true rails. The high-half memory is addressed from the complement rails, so it keeps entry k at location ~k. The write port takes a plain 16-bit half-word and a plain 8-bit index. The block itself interleaves the data and, for the high half, inverts the address.

A lookup is launched by a one-cycle `start`. Exactly one cycle later `done` pulses and `result` carries the selected interleaved half-word. In every other cycle `result` is forced to zero, so the output is precharged between evaluations. An index whose rails are not complementary is rejected with `err`. A table number outside the configured range is rejected the same way.

Top module: `dual_rail_sbox`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done`, `err` and `result` are all zero.
- R2: A lookup with `half_sel`=0 returns, one cycle after `start`, the low 16 bits of entry idx of table `tbl_sel` in interleaved form. Here idx is taken from the even bits of `lk_addr`.
- R3: A lookup with `half_sel`=1 returns the high 16 bits of the same entry in interleaved form. The high-half memory is addressed by the odd (complement) bits of `lk_addr`, so entries 0x00 and 0xFF stay distinct.
- R4: Interleaved form means result bit 2i equals half-word bit i and result bit 2i+1 equals its inverse, for i = 0..15.
- R5: Tables 0 to 4 are independent. A write to one table leaves the same index of every other table unchanged.
- R6: `result` is zero in every cycle where `done` is low.
- R7: If any pair (`lk_addr`[2i], `lk_addr`[2i+1]) is equal at `start`, then one cycle later `done` and `err` are both 1 and `result` is zero.
- R8: If `tbl_sel` is 5 or more at `start`, then one cycle later `done` and `err` are both 1 and `result` is zero.
- R9: A write with `wr_half`=0 changes only the low half of the entry and a write with `wr_half`=1 changes only the high half. A later lookup of the other half returns its old value.
- R10: `start` held high in consecutive cycles produces one `done` in each following cycle. Each `done` carries the result for the request of the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a lookup this cycle |
| tbl_sel | input | 3 | Table number for the lookup |
| half_sel | input | 1 | 0 = low half-word, 1 = high half-word |
| lk_addr | input | 16 | Dual-rail index, true rails on even bits |
| result | output | 32 | Interleaved half-word, zero unless `done` |
| done | output | 1 | Result valid this cycle |
| err | output | 1 | Request rejected (unbalanced index or bad table) |
| wr_en | input | 1 | Write strobe |
| wr_tbl | input | 3 | Table number for the write |
| wr_half | input | 1 | Half-word written: 0 low, 1 high |
| wr_idx | input | 8 | Plain table index for the write |
| wr_data | input | 16 | Plain half-word to store |

## Verification
The main lookup is driven with entries at indices 0x00, 0xFF, 0x80, 0x01 and 0xFE, spread over all five tables. These patterns separate true-rail from complement-rail addressing and show whether the high-half memory really stores at the inverted address. Entries with all-ones, all-zeros and alternating half-words expose any swap between the data bit and its complement, or between the two halves. An entirely unbalanced address, an address with a single bad pair, and an out-of-range table each test the reject path. A partial overwrite and a pair of back-to-back requests test half isolation and pipelining.

// File: rtl/drsb_pkg.sv
package drsb_pkg;
  localparam int unsigned DEF_IDX_W   = 8;
  localparam int unsigned DEF_HW_W    = 16;
  localparam int unsigned DEF_TABLES  = 5;

  localparam logic HALF_LO = 1'b0;
  localparam logic HALF_HI = 1'b1;
endpackage

// File: rtl/drsb_rail_split.sv
module drsb_rail_split #(
  parameter int unsigned IDX_W = 8
) (
  input  logic [2*IDX_W-1:0] baddr,
  output logic [IDX_W-1:0]   t_rail,
  output logic [IDX_W-1:0]   c_rail,
  output logic               bad
);
  logic [IDX_W-1:0] pair_bad;

  for (genvar i = 0; i < IDX_W; i++) begin : g_pair
    assign t_rail[i]   = baddr[2*i];
    assign c_rail[i]   = baddr[2*i+1];
    assign pair_bad[i] = ~(baddr[2*i] ^ baddr[2*i+1]);
  end

  assign bad = |pair_bad;
endmodule

// File: rtl/drsb_bi_pack.sv
module drsb_bi_pack #(
  parameter int unsigned HW_W = 16
) (
  input  logic [HW_W-1:0]   plain,
  output logic [2*HW_W-1:0] packed_q
);
  for (genvar i = 0; i < HW_W; i++) begin : g_bit
    assign packed_q[2*i]   = plain[i];
    assign packed_q[2*i+1] = ~plain[i];
  end
endmodule

// File: rtl/drsb_ram.sv
module drsb_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/drsb_bank.sv
module drsb_bank #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned HW_W  = 16,
  localparam int unsigned WW   = 2*HW_W
) (
  input  logic             clk,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [IDX_W-1:0] widx,
  input  logic [WW-1:0]    wword,
  input  logic             re_lo,
  input  logic             re_hi,
  input  logic [IDX_W-1:0] t_rail,
  input  logic [IDX_W-1:0] c_rail,
  output logic [WW-1:0]    q_lo,
  output logic [WW-1:0]    q_hi
);
  // Low half lives at the plain index; high half at its inverse.
  drsb_ram #(.AW(IDX_W), .DW(WW)) u_lo (
    .clk(clk), .we(we_lo), .waddr(widx), .wdata(wword),
    .re(re_lo), .raddr(t_rail), .rdata(q_lo)
  );

  drsb_ram #(.AW(IDX_W), .DW(WW)) u_hi (
    .clk(clk), .we(we_hi), .waddr(~widx), .wdata(wword),
    .re(re_hi), .raddr(c_rail), .rdata(q_hi)
  );
endmodule

// File: rtl/dual_rail_sbox.sv
module dual_rail_sbox #(
  parameter int unsigned IDX_W    = drsb_pkg::DEF_IDX_W,
  parameter int unsigned HW_W     = drsb_pkg::DEF_HW_W,
  parameter int unsigned N_TABLES = drsb_pkg::DEF_TABLES,
  localparam int unsigned TS_W    = (N_TABLES > 1) ? $clog2(N_TABLES) : 1,
  localparam int unsigned WW      = 2*HW_W,
  localparam int unsigned AW2     = 2*IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TS_W-1:0]  tbl_sel,
  input  logic             half_sel,
  input  logic [AW2-1:0]   lk_addr,
  output logic [WW-1:0]    result,
  output logic             done,
  output logic             err,
  input  logic             wr_en,
  input  logic [TS_W-1:0]  wr_tbl,
  input  logic             wr_half,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [HW_W-1:0]  wr_data
);
  import drsb_pkg::*;

  logic [IDX_W-1:0] t_rail, c_rail;
  logic             addr_bad;
  logic             tbl_ok;
  logic             fault;
  logic             rd_go;
  logic [WW-1:0]    wword;

  drsb_rail_split #(.IDX_W(IDX_W)) u_split (
    .baddr(lk_addr), .t_rail(t_rail), .c_rail(c_rail), .bad(addr_bad)
  );

  drsb_bi_pack #(.HW_W(HW_W)) u_pack (
    .plain(wr_data), .packed_q(wword)
  );

  assign tbl_ok = (32'(tbl_sel) < N_TABLES);
  assign fault  = addr_bad | ~tbl_ok;
  assign rd_go  = start & ~fault;

  logic [WW-1:0] q_lo [N_TABLES];
  logic [WW-1:0] q_hi [N_TABLES];

  for (genvar g = 0; g < N_TABLES; g++) begin : g_tbl
    logic hit_rd, hit_wr;
    assign hit_rd = rd_go & (tbl_sel == TS_W'(g));
    assign hit_wr = wr_en & (wr_tbl == TS_W'(g));

    drsb_bank #(.IDX_W(IDX_W), .HW_W(HW_W)) u_bank (
      .clk   (clk),
      .we_lo (hit_wr & (wr_half == HALF_LO)),
      .we_hi (hit_wr & (wr_half == HALF_HI)),
      .widx  (wr_idx),
      .wword (wword),
      .re_lo (hit_rd & (half_sel == HALF_LO)),
      .re_hi (hit_rd & (half_sel == HALF_HI)),
      .t_rail(t_rail),
      .c_rail(c_rail),
      .q_lo  (q_lo[g]),
      .q_hi  (q_hi[g])
    );
  end

  // Request bookkeeping aligned with the memory read stage.
  logic            done_q, err_q, half_q;
  logic [TS_W-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      half_q <= HALF_LO;
      tbl_q  <= '0;
    end else begin
      done_q <= start;
      err_q  <= start & fault;
      if (start) begin
        half_q <= half_sel;
        tbl_q  <= tbl_sel;
      end
    end
  end

  logic [WW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int t = 0; t < N_TABLES; t++) begin
      if (tbl_q == TS_W'(t)) pick = (half_q == HALF_HI) ? q_hi[t] : q_lo[t];
    end
  end

  // Precharge: the output rails stay low unless a good result is presented.
  assign result = (done_q & ~err_q) ? pick : '0;
  assign done   = done_q;
  assign err    = err_q;
endmodule

// File: rtl/dual_rail_sbox_chk.sv
module dual_rail_sbox_chk #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned HW_W     = 16,
  parameter int unsigned N_TABLES = 5,
  localparam int unsigned TS_W    = (N_TABLES > 1) ? $clog2(N_TABLES) : 1,
  localparam int unsigned WW      = 2*HW_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [TS_W-1:0]   tbl_sel,
  input logic [2*IDX_W-1:0] lk_addr,
  input logic [WW-1:0]     result,
  input logic              done,
  input logic              err
);
  function automatic logic [WW-1:0] even_mask();
    logic [WW-1:0] m;
    m = '0;
    for (int i = 0; i < HW_W; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  function automatic logic rails_ok(input logic [2*IDX_W-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < IDX_W; i++) if (a[2*i] == a[2*i+1]) ok = 1'b0;
    return ok;
  endfunction

  localparam logic [WW-1:0] EVEN = even_mask();

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !err && result == '0));

  // R6
  precharge_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> result == '0);

  // R10
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  // R7
  err_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && result == '0));

  // R7
  unbalanced_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !rails_ok(lk_addr)) |=> err);

  // R8
  bad_table_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && 32'(tbl_sel) >= N_TABLES) |=> err);

  // R4
  pair_balance_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (((result ^ (result >> 1)) & EVEN) == EVEN));
endmodule

bind dual_rail_sbox dual_rail_sbox_chk #(
  .IDX_W(IDX_W), .HW_W(HW_W), .N_TABLES(N_TABLES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .tbl_sel(tbl_sel),
  .lk_addr(lk_addr), .result(result), .done(done), .err(err)
);

// File: tb/dual_rail_sbox_test.sv
module dual_rail_sbox_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic        half_sel = 1'b0;
  logic [15:0] lk_addr = '0;
  logic [31:0] result;
  logic        done, err;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_tbl = '0;
  logic        wr_half = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  dual_rail_sbox uut (
    .clk(clk), .rst(rst), .start(start), .tbl_sel(tbl_sel),
    .half_sel(half_sel), .lk_addr(lk_addr), .result(result),
    .done(done), .err(err), .wr_en(wr_en), .wr_tbl(wr_tbl),
    .wr_half(wr_half), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [2:0]  tbl;
    logic [7:0]  idx;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h00, 32'hA5C3_0F1E},
    '{3'd0, 8'hFF, 32'h1234_5678},
    '{3'd1, 8'h00, 32'hFFFF_0000},
    '{3'd1, 8'h80, 32'h0000_FFFF},
    '{3'd2, 8'h5A, 32'hDEAD_BEEF},
    '{3'd3, 8'h01, 32'hCAFE_F00D},
    '{3'd4, 8'hFE, 32'h8001_7FFE},
    '{3'd4, 8'h33, 32'h0F0F_F0F0}
  };

  function automatic logic [31:0] bi(input logic [15:0] h);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      r[2*i]   = h[i];
      r[2*i+1] = ~h[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] rails(input logic [7:0] x);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = x[i];
      r[2*i+1] = ~x[i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {done,err,result} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] t, input logic h, input logic [7:0] i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = t; wr_half = h; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Launch one request; returns positioned in the cycle where done is valid.
  task automatic ask(input logic [2:0] t, input logic h, input logic [15:0] a);
    @(negedge clk);
    start = 1'b1; tbl_sel = t; half_sel = h; lk_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", {done, err, result}, 34'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {done, err, result}, 34'd0);

    for (int v = 0; v < NV; v++) begin
      put(VECS[v].tbl, 1'b0, VECS[v].idx, VECS[v].val[15:0]);
      put(VECS[v].tbl, 1'b1, VECS[v].idx, VECS[v].val[31:16]);
    end

    // R2 R3 R4 R5: every half of every entry through the vector table
    for (int v = 0; v < NV; v++) begin
      ask(VECS[v].tbl, 1'b0, rails(VECS[v].idx));
      check($sformatf("R2 R4 R5 low v%0d", v), {done, err, result}, {2'b10, bi(VECS[v].val[15:0])});
      ask(VECS[v].tbl, 1'b1, rails(VECS[v].idx));
      check($sformatf("R3 R4 R5 high v%0d", v), {done, err, result}, {2'b10, bi(VECS[v].val[31:16])});
    end

    // R6: idle cycle after a result is precharged
    @(negedge clk);
    check("R6 idle zero", {done, err, result}, 34'd0);

    // R9: rewrite only the low half of entry 0
    put(3'd0, 1'b0, 8'h00, 16'h3C3C);
    ask(3'd0, 1'b0, rails(8'h00));
    check("R9 new low", {done, err, result}, {2'b10, bi(16'h3C3C)});
    ask(3'd0, 1'b1, rails(8'h00));
    check("R9 high kept", {done, err, result}, {2'b10, bi(16'hA5C3)});

    // R7: all-zero address and a single bad pair
    ask(3'd0, 1'b0, 16'h0000);
    check("R7 all pairs bad", {done, err, result}, {2'b11, 32'd0});
    ask(3'd2, 1'b1, rails(8'h5A) | 16'h0080);
    check("R7 one pair bad", {done, err, result}, {2'b11, 32'd0});

    // R8: table numbers past the last
    ask(3'd5, 1'b0, rails(8'h00));
    check("R8 table 5", {done, err, result}, {2'b11, 32'd0});
    ask(3'd7, 1'b1, rails(8'h33));
    check("R8 table 7", {done, err, result}, {2'b11, 32'd0});

    // R10: back-to-back requests
    @(negedge clk);
    start = 1'b1; tbl_sel = 3'd3; half_sel = 1'b1; lk_addr = rails(8'h01);
    @(negedge clk);
    check("R10 first", {done, err, result}, {2'b10, bi(16'hCAFE)});
    tbl_sel = 3'd4; half_sel = 1'b0; lk_addr = rails(8'hFE);
    @(negedge clk);
    check("R10 second", {done, err, result}, {2'b10, bi(16'h7FFE)});
    start = 1'b0;
    @(negedge clk);
    check("R6 R10 drop after burst", {done, err, result}, 34'd0);

    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule